// File: doc/BRIEF.md
# Nested Exception Escalation Classifier

This block sits between the fault sources of a processor core and its exception delivery sequencer. Each raised exception arrives as a 5-bit vector and a 16-bit error code on a valid/ready handshake. The block decodes the vector into a severity class and decides whether an error code is delivered. It also decides whether the resume flag must be set in the saved flags image. It then forms the final error code by inserting the external-event bit into bit 0.

While an earlier exception is still being delivered, the block remembers the class of that first exception and how many exceptions have nested on top of it. A forbidden combination of first and second class becomes a double fault, vector 8. An exception that arrives after a double fault, or a third one at any depth, raises a shutdown pulse. After a shutdown the block refuses further requests. When the sequencer finishes a delivery it pulses `resolved`, which clears the nesting history.

Top module: `exc_escalator`

## Requirements
- R1: Classes are benign for vectors 1-7 and 16, contributory for vectors 0 and 9-13, page fault for vector 14, and double fault for vector 8. A double-fault-class request that arrives as a nested exception is treated as contributory.
- R2: `out_push_err` is 1 for delivered vectors 8, 10, 11, 12, 13 and 14, and 0 for all others.
- R3: `out_rf_set` is 1 for delivered vectors 0, 5, 6, 7, 9-14 and 16, and 0 for vectors 1-4 and 8.
- R4: For every class except page fault, `out_err` is the request code with bit 0 replaced by the external-event bit. For page faults, `out_err` equals the request code. The external-event bit is 0 after reset or `resolved`, and becomes 1 after any accepted valid exception.
- R5: A nested exception is delivered unchanged when the first exception was benign, when the new one is benign, or when a page fault follows a contributory exception.
- R6: Contributory after contributory, and contributory or page fault after a page fault, are delivered as vector 8 with `out_push_err`=1, `out_rf_set`=0 and `out_err`=0.
- R7: `shutdown` pulses for one cycle, with `out_valid`=0, when a request is accepted at nesting depth 2 (the third exception). It also pulses when a request is accepted at nesting depth 1 and the first exception was of double-fault class.
- R8: Vector 15 and vectors 17-31 are delivered with `out_invalid`=1, the vector echoed, `out_push_err`=0, `out_rf_set`=0 and `out_err` equal to the request code. They leave the nesting depth, the first class and the external-event bit unchanged.
- R9: A `resolved` pulse clears the nesting depth, the first class, the external-event bit and the halt, so the next exception is treated as a first one. `req_ready` is low in the cycle `resolved` is high.
- R10: After a shutdown, `req_ready` stays low and requests are ignored, with no output pulse, until `resolved`.
- R11: Outputs are registered. `out_valid` or `shutdown` rises in the cycle after acceptance and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Block can accept a request |
| req_vector | input | 5 | Raised exception vector |
| req_err | input | 16 | Raw error code |
| resolved | input | 1 | Delivery finished, clear nesting history |
| out_valid | output | 1 | Delivery decision valid (one cycle) |
| out_vector | output | 5 | Vector to deliver |
| out_push_err | output | 1 | An error code is delivered |
| out_err | output | 16 | Final error code |
| out_rf_set | output | 1 | Set resume flag in the saved flags |
| out_invalid | output | 1 | Requested vector is not supported |
| shutdown | output | 1 | Unrecoverable nesting, one-cycle pulse |

## Verification
The hardest states to reach are deep in the nesting history: a request after a first double fault, a third exception, and requests offered while halted. A purely random stream resolves too often to reach them. The stimulus therefore runs random bursts of one to four requests and skips `resolved` between bursts about a quarter of the time, so that depth builds up across bursts. Directed sequences hit each pairing of the class matrix, a first double fault, an invalid vector in the middle of a nest, and a request offered while halted.

// File: rtl/exc_pkg.sv
// Shared types for the nested exception classifier.
// Assumes a 2-bit class code; no storage here.
package exc_pkg;
    typedef enum logic [1:0] {
        CLS_BENIGN  = 2'd0,
        CLS_CONTRIB = 2'd1,
        CLS_PFAULT  = 2'd2,
        CLS_DFAULT  = 2'd3
    } exc_cls_t;
endpackage

// File: rtl/exc_decode.sv
// Vector decoder: maps a raised vector to its class, error-push need,
// resume-flag need and validity. Purely combinational.
// Assumes VEC_W is wide enough to hold vector 16.
module exc_decode
    import exc_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic [VEC_W-1:0] vec,
    output exc_cls_t         cls,
    output logic             push_err,
    output logic             rf_set,
    output logic             invalid
);
    // Decode the vector into its attributes.
    always_comb begin
        cls      = CLS_BENIGN;
        push_err = 1'b0;
        rf_set   = 1'b0;
        invalid  = 1'b0;
        case (vec)
            'd0:                 begin cls = CLS_CONTRIB; rf_set = 1'b1; end
            'd1, 'd2, 'd3, 'd4:  cls = CLS_BENIGN;
            'd5, 'd6, 'd7:       begin cls = CLS_BENIGN; rf_set = 1'b1; end
            'd8:                 begin cls = CLS_DFAULT; push_err = 1'b1; end
            'd9:                 begin cls = CLS_CONTRIB; rf_set = 1'b1; end
            'd10, 'd11, 'd12, 'd13: begin
                cls = CLS_CONTRIB; push_err = 1'b1; rf_set = 1'b1;
            end
            'd14:                begin cls = CLS_PFAULT; push_err = 1'b1; rf_set = 1'b1; end
            'd16:                begin cls = CLS_BENIGN; rf_set = 1'b1; end
            default:             invalid = 1'b1;
        endcase
    end
endmodule

// File: rtl/exc_pair_check.sv
// Pair check: decides whether a nested exception may be delivered as is,
// given the class of the first one. A nested double-fault-class request
// counts as contributory. Purely combinational.
module exc_pair_check
    import exc_pkg::*;
(
    input  exc_cls_t first_cls,
    input  exc_cls_t new_cls,
    output logic     allowed
);
    exc_cls_t eff_cls;

    // Fold a nested double-fault request onto the contributory class.
    always_comb eff_cls = (new_cls == CLS_DFAULT) ? CLS_CONTRIB : new_cls;

    // Apply the class matrix.
    always_comb begin
        allowed = 1'b1;
        if (first_cls == CLS_CONTRIB && eff_cls == CLS_CONTRIB)
            allowed = 1'b0;
        if (first_cls == CLS_PFAULT &&
            (eff_cls == CLS_CONTRIB || eff_cls == CLS_PFAULT))
            allowed = 1'b0;
    end
endmodule

// File: rtl/exc_nest_ctrl.sv
// Nesting controller: holds the depth count, the first class, the
// external-event bit and the halt flag, and flags escalation or shutdown
// for the request being taken. Assumes take is only high for valid vectors.
module exc_nest_ctrl
    import exc_pkg::*;
#(
    parameter int DEPTH_LIMIT = 3,
    localparam int CNT_W = $clog2(DEPTH_LIMIT + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     take,
    input  exc_cls_t cls,
    input  logic     resolved,
    output logic     escalate,
    output logic     shut,
    output logic     ext_bit,
    output logic     halted
);
    localparam logic [CNT_W-1:0] LAST_DEPTH = CNT_W'(DEPTH_LIMIT - 1);

    logic [CNT_W-1:0] depth_q;
    exc_cls_t         first_q;
    logic             allowed;

    exc_pair_check u_pair (
        .first_cls (first_q),
        .new_cls   (cls),
        .allowed   (allowed)
    );

    // Decide the fate of the request being taken.
    always_comb begin
        shut     = take && ((depth_q >= LAST_DEPTH) ||
                            (depth_q != '0 && first_q == CLS_DFAULT));
        escalate = take && !shut && (depth_q != '0) && !allowed;
    end

    // Update nesting history.
    always_ff @(posedge clk) begin
        if (!rst_n || resolved) begin
            depth_q <= '0;
            first_q <= CLS_BENIGN;
            ext_bit <= 1'b0;
            halted  <= 1'b0;
        end else if (take) begin
            ext_bit <= 1'b1;
            if (depth_q == '0) first_q <= cls;
            if (shut) halted <= 1'b1;
            if (depth_q < LAST_DEPTH) depth_q <= depth_q + 1'b1;
        end
    end

    // R9
    resolved_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resolved |=> (depth_q == '0 && !ext_bit && !halted));
    // R7
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= LAST_DEPTH);
    // R4
    ext_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !resolved) |=> ext_bit);
endmodule

// File: rtl/exc_escalator.sv
// Top of the nested exception classifier. Accepts one request per
// valid/ready handshake, decodes it, consults the nesting controller and
// registers the delivery decision or a shutdown pulse one cycle later.
// Assumes resolved is a single-cycle pulse from the delivery sequencer.
module exc_escalator
    import exc_pkg::*;
#(
    parameter int VEC_W       = 5,
    parameter int ERR_W       = 16,
    parameter int DEPTH_LIMIT = 3,
    parameter int DF_VECTOR   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VEC_W-1:0] req_vector,
    input  logic [ERR_W-1:0] req_err,
    input  logic             resolved,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vector,
    output logic             out_push_err,
    output logic [ERR_W-1:0] out_err,
    output logic             out_rf_set,
    output logic             out_invalid,
    output logic             shutdown
);
    exc_cls_t cls;
    logic     dec_push, dec_rf, dec_inv;
    logic     accept, take, escalate, shut, ext_bit, halted;
    logic [ERR_W-1:0] merged_err;

    exc_decode #(.VEC_W(VEC_W)) u_dec (
        .vec      (req_vector),
        .cls      (cls),
        .push_err (dec_push),
        .rf_set   (dec_rf),
        .invalid  (dec_inv)
    );

    // Handshake: refuse while halted or while history is being cleared.
    always_comb begin
        req_ready = !halted && !resolved;
        accept    = req_valid && req_ready;
        take      = accept && !dec_inv;
    end

    exc_nest_ctrl #(.DEPTH_LIMIT(DEPTH_LIMIT)) u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .cls      (cls),
        .resolved (resolved),
        .escalate (escalate),
        .shut     (shut),
        .ext_bit  (ext_bit),
        .halted   (halted)
    );

    // Insert the external-event bit except for page faults.
    always_comb begin
        merged_err = req_err;
        if (!dec_inv && cls != CLS_PFAULT) merged_err[0] = ext_bit;
    end

    // Register the delivery decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_vector   <= '0;
            out_push_err <= 1'b0;
            out_err      <= '0;
            out_rf_set   <= 1'b0;
            out_invalid  <= 1'b0;
            shutdown     <= 1'b0;
        end else begin
            out_valid <= accept && !shut;
            shutdown  <= shut;
            if (accept) begin
                out_invalid <= dec_inv;
                if (escalate) begin
                    out_vector   <= VEC_W'(DF_VECTOR);
                    out_push_err <= 1'b1;
                    out_err      <= '0;
                    out_rf_set   <= 1'b0;
                end else begin
                    out_vector   <= req_vector;
                    out_push_err <= dec_push && !dec_inv;
                    out_err      <= merged_err;
                    out_rf_set   <= dec_rf && !dec_inv;
                end
            end
        end
    end

    // R7
    shut_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> !out_valid);
    // R10
    halt_after_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> !req_ready);
    // R11
    shut_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> !shutdown);
    // R3
    df_no_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_vector == VEC_W'(DF_VECTOR)) |-> !out_rf_set);
    // R2
    push_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_push_err) |->
        (out_vector == 5'd8 || (out_vector >= 5'd10 && out_vector <= 5'd14)));
    // R11
    valid_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_valid));
endmodule

// File: tb/sim_exc_escalator.sv
`timescale 1ns/1ps
module sim_exc_escalator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_vector = '0;
    logic [15:0] req_err = '0;
    logic        resolved = 1'b0;
    logic        out_valid, out_push_err, out_rf_set, out_invalid, shutdown;
    logic [4:0]  out_vector;
    logic [15:0] out_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    int m_dep = 0;
    int m_first = 0;
    bit m_ext = 0;
    bit m_halt = 0;

    always #4 clk = ~clk;

    exc_escalator u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vector(req_vector), .req_err(req_err), .resolved(resolved),
        .out_valid(out_valid), .out_vector(out_vector), .out_push_err(out_push_err),
        .out_err(out_err), .out_rf_set(out_rf_set), .out_invalid(out_invalid),
        .shutdown(shutdown)
    );

    function automatic int cls_of(input int v);
        if (v == 0 || (v >= 9 && v <= 13)) return 1;
        if (v == 14) return 2;
        if (v == 8) return 3;
        return 0;
    endfunction
    function automatic bit inv_of(input int v);
        return (v == 15 || v > 16);
    endfunction
    function automatic bit push_of(input int v);
        return (v == 8 || (v >= 10 && v <= 14));
    endfunction
    function automatic bit rf_of(input int v);
        return (v == 0 || (v >= 5 && v <= 7) || (v >= 9 && v <= 14) || v == 16);
    endfunction
    function automatic bit ok_pair(input int f, input int s);
        int e;
        e = (s == 3) ? 1 : s;
        if (f == 1 && e == 1) return 0;
        if (f == 2 && (e == 1 || e == 2)) return 0;
        return 1;
    endfunction

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input int v, input logic [15:0] e);
        bit e_valid, e_shut, e_push, e_rf, e_inv, shut, esc;
        int e_vec, c;
        logic [15:0] e_err;
        @(negedge clk);
        chk(out_valid == 1'b0 && shutdown == 1'b0, "R11 pulse", out_valid, 0);
        chk(req_ready == !m_halt, "R10 ready", req_ready, !m_halt);
        req_valid = 1'b1; req_vector = 5'(v); req_err = e;
        @(negedge clk);
        req_valid = 1'b0;
        e_valid = 0; e_shut = 0; e_vec = v; e_push = 0; e_rf = 0; e_inv = 0; e_err = e;
        if (m_halt) begin
            e_valid = 0;
        end else if (inv_of(v)) begin
            e_valid = 1; e_inv = 1;
        end else begin
            c = cls_of(v);
            shut = (m_dep >= 2) || (m_dep != 0 && m_first == 3);
            esc = !shut && m_dep != 0 && !ok_pair(m_first, c);
            if (shut) e_shut = 1;
            else if (esc) begin
                e_valid = 1; e_vec = 8; e_push = 1; e_rf = 0; e_err = 16'h0;
            end else begin
                e_valid = 1; e_push = push_of(v); e_rf = rf_of(v);
                e_err = (c == 2) ? e : {e[15:1], m_ext};
            end
            m_ext = 1;
            if (m_dep == 0) m_first = c;
            if (shut) m_halt = 1;
            if (m_dep < 2) m_dep++;
        end
        chk(out_valid == e_valid, "R11 out_valid", out_valid, e_valid);
        chk(shutdown == e_shut, "R7 shutdown", shutdown, e_shut);
        if (e_valid) begin
            chk(out_vector == 5'(e_vec), "R6 vector", out_vector, e_vec);
            chk(out_push_err == e_push, "R2 push", out_push_err, e_push);
            chk(out_rf_set == e_rf, "R3 rf", out_rf_set, e_rf);
            chk(out_err == e_err, "R4 err", out_err, e_err);
            chk(out_invalid == e_inv, "R8 invalid", out_invalid, e_inv);
        end
    endtask

    task automatic resolve();
        @(negedge clk);
        resolved = 1'b1;
        #1 chk(req_ready == 1'b0, "R9 ready during resolved", req_ready, 0);
        @(negedge clk);
        resolved = 1'b0;
        m_dep = 0; m_first = 0; m_ext = 0; m_halt = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(out_valid == 0 && shutdown == 0, "R11 reset", out_valid, 0);
        chk(req_ready == 1, "R10 reset ready", req_ready, 1);
        // R1 R4: first contributory, ext 0 in bit0
        send(13, 16'hFFFF); send(14, 16'h1235); resolve();
        // R6: contributory after contributory
        send(0, 16'h0); send(11, 16'h00A1); resolve();
        // R6: page fault after page fault
        send(14, 16'h0007); send(14, 16'h0003); resolve();
        // R5: benign first, then page fault second; benign after PF
        send(3, 16'h0); send(14, 16'h0); resolve();
        send(14, 16'h0); send(6, 16'h0); resolve();
        // R7: third exception shuts down, R10 halted ignores
        send(1, 16'h0); send(2, 16'h0); send(4, 16'h0); send(12, 16'h55); resolve();
        // R7: second after double fault
        send(8, 16'h0); send(1, 16'h0); resolve();
        // R8: invalid in the middle leaves state
        send(10, 16'h0); send(15, 16'hABCD); send(31, 16'h1); send(9, 16'h0); resolve();
        // R1: nested vector 8 counts as contributory
        send(13, 16'h0); send(8, 16'h0); resolve();
        // R9: resolved restarts
        send(16, 16'h0); resolve(); send(0, 16'h0); send(5, 16'h0); resolve();
        void'($urandom(32'd1234));
        for (int r = 0; r < 400; r++) begin
            int n;
            n = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++)
                send(int'($urandom % 32), 16'($urandom));
            if ($urandom % 4 != 0) resolve();
        end
        resolve();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule